// File: doc/BRIEF.md
# Compressed Display Line Coherency Controller

This block decides, line by line, where display refresh data is fetched from. One path is a compressed copy held in off-screen memory. The other is the uncompressed frame buffer. The decision rests on two bits kept on chip for every display line:

- A **valid** bit records that a good compressed copy exists.
- A **dirty** bit records that the frame buffer has been written since that copy was made.

The display engine asks about a line and gets the answer one cycle later.

Frame-buffer writes are snooped by line index and mark lines dirty. A programmable count of static frames lets the controller ignore the dirty bits for several frames in a row. During those frames the valid bit alone selects the source, so the visible image updates more slowly than the refresh rate.

While an uncompressed line is being shown, an external compressor streams its output words into a 64 x 32-bit on-chip line buffer. At the end of the line the compressor reports success or failure. Only a successful line with a length that fits is streamed out on the write-back port. That same success commits the line as valid and clean.

Top module: `cdl_coherency_ctrl`

## Requirements
- R1: After reset every line is invalid and dirty, so every query answers uncompressed (`resp_comp_o`=0), and `wb_vld_o` stays low.
- R2: A query pulse yields `resp_vld_o`=1 on the next cycle with the queried line echoed. `resp_comp_o` is 1 (compressed source) exactly when the line is valid and either it is not dirty or the static counter is nonzero.
- R3: A snooped write sets the dirty bit of the addressed line and leaves its valid bit unchanged.
- R4: On each frame-start pulse the static counter loads `static_frames_i` if it is zero and otherwise decrements. Dirty bits are ignored while the counter is nonzero. The counter is zero after reset.
- R5: Compressed words arriving with `cmp_word_vld_i` are stored in order, up to 64 per line. A successful end starts a write-back on the next cycle. The write-back emits one word per cycle, with `wb_addr_o` counting from 0 and `wb_last_o` marking the final word.
- R6: A successful end sets the line's valid bit and clears its dirty bit. A query issued in the following cycle sees this.
- R7: An end with `cmp_ok_i`=0 produces no write-back and leaves both bits of the line unchanged.
- R8: A line with more than 64 words, or with zero words, counts as failed: no write-back and no state change.
- R9: A snooped write to the same line in the same cycle as a successful end leaves that line dirty.
- R10: While a write-back is in progress, incoming words are dropped and an end is failed. A line that lost any word fails at its end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| static_frames_i | input | STATIC_W | Number of static frames inserted between dirty-honouring frames |
| frame_start_i | input | 1 | Frame start pulse |
| snoop_vld_i | input | 1 | Frame-buffer write snoop strobe |
| snoop_line_i | input | LINE_W | Line index of the snooped write |
| query_vld_i | input | 1 | Source query strobe |
| query_line_i | input | LINE_W | Line index being queried |
| resp_vld_o | output | 1 | Query response strobe |
| resp_line_o | output | LINE_W | Line index of the response |
| resp_comp_o | output | 1 | 1 = fetch compressed copy, 0 = fetch frame buffer |
| cmp_word_vld_i | input | 1 | Compressed word strobe |
| cmp_word_i | input | WORD_W | Compressed word |
| cmp_end_i | input | 1 | End of compressed line |
| cmp_ok_i | input | 1 | Compression status, sampled with end |
| cmp_line_i | input | LINE_W | Line index, sampled with end |
| wb_vld_o | output | 1 | Write-back word valid |
| wb_line_o | output | LINE_W | Line being written back |
| wb_addr_o | output | PTR_W | Word index within the line |
| wb_data_o | output | WORD_W | Write-back word |
| wb_last_o | output | 1 | Final word of the write-back |

## Verification
The bench builds the controller with 16 lines and a 3-bit static count, keeping the default 64-word buffer. With only 16 lines, the reset state of every line can be checked by a full sweep of queries. The buffer keeps its real depth, so the exact-64-word write-back and the 65-word overflow are both exercised at the true boundary. The small static count allows a complete load, decrement and reload cycle within a few frames. A 64-word write-back gives a long busy window in which another line's words and end can be injected.

// File: rtl/cdl_pkg.sv
package cdl_pkg;
  typedef enum logic {
    SRC_FRAME = 1'b0,
    SRC_COMP  = 1'b1
  } src_e;

  function automatic src_e pick_src(input logic valid, input logic dirty, input logic static_act);
    return (valid && (!dirty || static_act)) ? SRC_COMP : SRC_FRAME;
  endfunction
endpackage

// File: rtl/cdl_static_cnt.sv
module cdl_static_cnt #(
  parameter int STATIC_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [STATIC_W-1:0] static_frames_i,
  input  logic                frame_start_i,
  output logic                static_act_o
);
  logic [STATIC_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (frame_start_i) cnt_q <= (cnt_q == '0) ? static_frames_i : cnt_q - 1'b1;
  end

  assign static_act_o = (cnt_q != '0);

  // R4
  cnt_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R4
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(cnt_q));
endmodule

// File: rtl/cdl_line_state.sv
module cdl_line_state
  import cdl_pkg::*;
#(
  parameter int NUM_LINES = 1024,
  parameter int LINE_W    = $clog2(NUM_LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              static_act_i,
  input  logic              snoop_vld_i,
  input  logic [LINE_W-1:0] snoop_line_i,
  input  logic              commit_i,
  input  logic [LINE_W-1:0] commit_line_i,
  input  logic              query_vld_i,
  input  logic [LINE_W-1:0] query_line_i,
  output logic              resp_vld_o,
  output logic [LINE_W-1:0] resp_line_o,
  output logic              resp_comp_o
);
  logic [NUM_LINES-1:0] valid_q;
  logic [NUM_LINES-1:0] dirty_q;
  src_e                 src_d;

  always_comb src_d = pick_src(valid_q[query_line_i], dirty_q[query_line_i], static_act_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '1;
    end else begin
      if (commit_i) begin
        valid_q[commit_line_i] <= 1'b1;
        dirty_q[commit_line_i] <= 1'b0;
      end
      // snoop after commit: dirty wins on a same-line collision
      if (snoop_vld_i) dirty_q[snoop_line_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_vld_o  <= 1'b0;
      resp_line_o <= '0;
      resp_comp_o <= 1'b0;
    end else begin
      resp_vld_o <= query_vld_i;
      if (query_vld_i) begin
        resp_line_o <= query_line_i;
        resp_comp_o <= (src_d == SRC_COMP);
      end
    end
  end

  // R3
  snoop_dirty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_vld_i |=> dirty_q[$past(snoop_line_i)]);
  // R3
  snoop_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snoop_vld_i && !(commit_i && commit_line_i == snoop_line_i))
      |=> (valid_q[$past(snoop_line_i)] == $past(valid_q[snoop_line_i])));
  // R6
  commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !(snoop_vld_i && snoop_line_i == commit_line_i))
      |=> (valid_q[$past(commit_line_i)] && !dirty_q[$past(commit_line_i)]));
  // R2
  invalid_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (query_vld_i && !valid_q[query_line_i]) |=> (resp_vld_o && !resp_comp_o));
endmodule

// File: rtl/cdl_line_buf.sv
module cdl_line_buf #(
  parameter int DEPTH  = 64,
  parameter int WORD_W = 32,
  parameter int LINE_W = 10,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_vld_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              end_i,
  input  logic              ok_i,
  input  logic [LINE_W-1:0] line_i,
  output logic              commit_o,
  output logic [LINE_W-1:0] commit_line_o,
  output logic              wb_vld_o,
  output logic [LINE_W-1:0] wb_line_o,
  output logic [PTR_W-1:0]  wb_addr_o,
  output logic [WORD_W-1:0] wb_data_o,
  output logic              wb_last_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0]  fill_q;
  logic              bad_q;
  logic              busy_q;
  logic [PTR_W-1:0]  rd_q;
  logic [PTR_W-1:0]  last_q;
  logic [LINE_W-1:0] wb_line_q;

  logic             full;
  logic             wr_en;
  logic             lost;
  logic [CNT_W-1:0] total;

  always_comb begin
    full     = (fill_q == CNT_W'(DEPTH));
    wr_en    = word_vld_i && !busy_q && !full;
    lost     = word_vld_i && (busy_q || full);
    total    = fill_q + CNT_W'(wr_en);
    commit_o = end_i && ok_i && !busy_q && !bad_q && !lost && (total != '0);
  end

  assign commit_line_o = line_i;

  always_ff @(posedge clk_i) begin
    if (wr_en) mem_q[fill_q[PTR_W-1:0]] <= word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      bad_q  <= 1'b0;
    end else if (end_i) begin
      fill_q <= '0;
      bad_q  <= 1'b0;
    end else begin
      if (wr_en) fill_q <= fill_q + 1'b1;
      if (lost)  bad_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      rd_q      <= '0;
      last_q    <= '0;
      wb_line_q <= '0;
    end else if (commit_o) begin
      busy_q    <= 1'b1;
      rd_q      <= '0;
      last_q    <= PTR_W'(total - 1'b1);
      wb_line_q <= line_i;
    end else if (busy_q) begin
      if (rd_q == last_q) busy_q <= 1'b0;
      else                rd_q   <= rd_q + 1'b1;
    end
  end

  assign wb_vld_o  = busy_q;
  assign wb_line_o = wb_line_q;
  assign wb_addr_o = rd_q;
  assign wb_data_o = mem_q[rd_q];
  assign wb_last_o = busy_q && (rd_q == last_q);

  // R5
  wb_cont_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_vld_o && !wb_last_o) |=> (wb_vld_o && wb_addr_o == $past(wb_addr_o) + 1'b1));
  // R5
  wb_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> (wb_vld_o && wb_addr_o == '0));
  // R8
  fill_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= CNT_W'(DEPTH));
  // R10
  no_commit_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_vld_o && !wb_last_o) |-> !commit_o);
  // R7
  fail_no_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_i && !ok_i && !wb_vld_o) |=> !wb_vld_o);
endmodule

// File: rtl/cdl_coherency_ctrl.sv
module cdl_coherency_ctrl #(
  parameter int NUM_LINES = 1024,
  parameter int DEPTH     = 64,
  parameter int WORD_W    = 32,
  parameter int STATIC_W  = 4,
  localparam int LINE_W   = $clog2(NUM_LINES),
  localparam int PTR_W    = $clog2(DEPTH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [STATIC_W-1:0] static_frames_i,
  input  logic                frame_start_i,
  input  logic                snoop_vld_i,
  input  logic [LINE_W-1:0]   snoop_line_i,
  input  logic                query_vld_i,
  input  logic [LINE_W-1:0]   query_line_i,
  output logic                resp_vld_o,
  output logic [LINE_W-1:0]   resp_line_o,
  output logic                resp_comp_o,
  input  logic                cmp_word_vld_i,
  input  logic [WORD_W-1:0]   cmp_word_i,
  input  logic                cmp_end_i,
  input  logic                cmp_ok_i,
  input  logic [LINE_W-1:0]   cmp_line_i,
  output logic                wb_vld_o,
  output logic [LINE_W-1:0]   wb_line_o,
  output logic [PTR_W-1:0]    wb_addr_o,
  output logic [WORD_W-1:0]   wb_data_o,
  output logic                wb_last_o
);
  logic              static_act;
  logic              commit;
  logic [LINE_W-1:0] commit_line;

  cdl_static_cnt #(.STATIC_W(STATIC_W)) u_static (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .static_frames_i (static_frames_i),
    .frame_start_i   (frame_start_i),
    .static_act_o    (static_act)
  );

  cdl_line_buf #(.DEPTH(DEPTH), .WORD_W(WORD_W), .LINE_W(LINE_W)) u_buf (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .word_vld_i    (cmp_word_vld_i),
    .word_i        (cmp_word_i),
    .end_i         (cmp_end_i),
    .ok_i          (cmp_ok_i),
    .line_i        (cmp_line_i),
    .commit_o      (commit),
    .commit_line_o (commit_line),
    .wb_vld_o      (wb_vld_o),
    .wb_line_o     (wb_line_o),
    .wb_addr_o     (wb_addr_o),
    .wb_data_o     (wb_data_o),
    .wb_last_o     (wb_last_o)
  );

  cdl_line_state #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_state (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .static_act_i  (static_act),
    .snoop_vld_i   (snoop_vld_i),
    .snoop_line_i  (snoop_line_i),
    .commit_i      (commit),
    .commit_line_i (commit_line),
    .query_vld_i   (query_vld_i),
    .query_line_i  (query_line_i),
    .resp_vld_o    (resp_vld_o),
    .resp_line_o   (resp_line_o),
    .resp_comp_o   (resp_comp_o)
  );

  // R1
  wb_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !wb_vld_o);
endmodule

// File: tb/cdl_coherency_ctrl_tb.sv
module cdl_coherency_ctrl_tb;
  localparam int NL = 16;
  localparam int SW = 3;
  localparam int LW = $clog2(NL);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [SW-1:0] static_frames = '0;
  logic          frame_start = 1'b0;
  logic          snoop_vld = 1'b0;
  logic [LW-1:0] snoop_line = '0;
  logic          query_vld = 1'b0;
  logic [LW-1:0] query_line = '0;
  logic          resp_vld;
  logic [LW-1:0] resp_line;
  logic          resp_comp;
  logic          cmp_vld = 1'b0;
  logic [31:0]   cmp_word = '0;
  logic          cmp_end = 1'b0;
  logic          cmp_ok = 1'b0;
  logic [LW-1:0] cmp_line = '0;
  logic          wb_vld;
  logic [LW-1:0] wb_line;
  logic [5:0]    wb_addr;
  logic [31:0]   wb_data;
  logic          wb_last;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  cdl_coherency_ctrl #(.NUM_LINES(NL), .DEPTH(64), .WORD_W(32), .STATIC_W(SW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .static_frames_i(static_frames), .frame_start_i(frame_start),
    .snoop_vld_i(snoop_vld), .snoop_line_i(snoop_line), .query_vld_i(query_vld),
    .query_line_i(query_line), .resp_vld_o(resp_vld), .resp_line_o(resp_line),
    .resp_comp_o(resp_comp), .cmp_word_vld_i(cmp_vld), .cmp_word_i(cmp_word),
    .cmp_end_i(cmp_end), .cmp_ok_i(cmp_ok), .cmp_line_i(cmp_line), .wb_vld_o(wb_vld),
    .wb_line_o(wb_line), .wb_addr_o(wb_addr), .wb_data_o(wb_data), .wb_last_o(wb_last)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int line, input int i);
    return 32'hA500_0000 | (line << 8) | i;
  endfunction

  task automatic query(input int line, input bit exp, input string req);
    @(negedge clk);
    query_vld = 1'b1; query_line = LW'(line);
    @(negedge clk);
    query_vld = 1'b0;
    chk(resp_vld && resp_line == LW'(line) && resp_comp == exp, req,
        {resp_vld, resp_comp}, {1'b1, exp});
  endtask

  task automatic frame;
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  // drive n words then an end; optional same-cycle snoop; check write-back
  task automatic run_line(input int line, input int n, input bit ok, input bit exp_wb,
                          input bit snp, input int snp_line, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cmp_vld = 1'b1; cmp_word = pat(line, i);
    end
    @(negedge clk);
    cmp_vld = 1'b0; cmp_end = 1'b1; cmp_ok = ok; cmp_line = LW'(line);
    snoop_vld = snp; snoop_line = LW'(snp_line);
    @(negedge clk);
    cmp_end = 1'b0; cmp_ok = 1'b0; snoop_vld = 1'b0;
    if (exp_wb) begin
      for (int i = 0; i < n; i++) begin
        if (i > 0) @(negedge clk);
        if (!(wb_vld && wb_line == LW'(line) && wb_addr == 6'(i) &&
              wb_data == pat(line, i) && wb_last == (i == n - 1))) bad++;
      end
      chk(bad == 0, req, bad, 0);
      @(negedge clk);
      chk(!wb_vld, req, wb_vld, 0);
    end else begin
      for (int i = 0; i < 4; i++) begin
        if (wb_vld) bad++;
        @(negedge clk);
      end
      chk(bad == 0, req, bad, 0);
    end
  endtask

  task automatic t_reset;
    for (int l = 0; l < NL; l++) query(l, 1'b0, "R1 reset line uncompressed");
    chk(!wb_vld, "R1 no write-back after reset", wb_vld, 0);
  endtask

  task automatic t_success;
    run_line(3, 5, 1'b1, 1'b1, 1'b0, 0, "R5 write-back stream 5 words");
    query(3, 1'b1, "R6 R2 committed line compressed");
    query(4, 1'b0, "R2 other line still uncompressed");
    run_line(12, 64, 1'b1, 1'b1, 1'b0, 0, "R5 exact 64-word write-back");
    query(12, 1'b1, "R6 64-word line compressed");
  endtask

  task automatic t_snoop_static;
    @(negedge clk); snoop_vld = 1'b1; snoop_line = LW'(3);
    @(negedge clk); snoop_vld = 1'b0;
    query(3, 1'b0, "R3 snooped line goes uncompressed");
    static_frames = 3'd2;
    frame;  // counter 0 -> 2
    query(3, 1'b1, "R4 R3 static frame uses valid only");
    query(5, 1'b0, "R4 invalid line stays uncompressed in static frame");
    frame;  // 2 -> 1
    query(3, 1'b1, "R4 second static frame");
    frame;  // 1 -> 0
    query(3, 1'b0, "R4 counter zero honours dirty");
    frame;  // 0 -> 2
    query(3, 1'b1, "R4 counter reloads");
    static_frames = 3'd0;
    frame; frame;  // 2 -> 1 -> 0
    query(3, 1'b0, "R4 back to honouring dirty");
    frame;  // 0 -> 0
    query(3, 1'b0, "R4 zero count never static");
  endtask

  task automatic t_fail;
    run_line(5, 6, 1'b0, 1'b0, 1'b0, 0, "R7 failed status no write-back");
    query(5, 1'b0, "R7 failed line stays uncompressed");
    run_line(12, 4, 1'b0, 1'b0, 1'b0, 0, "R7 failed status on valid clean line");
    query(12, 1'b1, "R7 failed line keeps its bits");
    run_line(6, 65, 1'b1, 1'b0, 1'b0, 0, "R8 65 words is a failure");
    query(6, 1'b0, "R8 overflowed line uncompressed");
    run_line(7, 0, 1'b1, 1'b0, 1'b0, 0, "R8 zero words is a failure");
    query(7, 1'b0, "R8 empty line uncompressed");
  endtask

  task automatic t_collide;
    run_line(8, 3, 1'b1, 1'b1, 1'b1, 8, "R9 write-back still runs on collision");
    query(8, 1'b0, "R9 same-cycle snoop keeps line dirty");
    run_line(9, 3, 1'b1, 1'b1, 1'b1, 10, "R9 snoop to other line");
    query(9, 1'b1, "R9 commit line unaffected by other snoop");
    query(10, 1'b0, "R3 snooped invalid line uncompressed");
  endtask

  task automatic t_busy;
    int cnt = 0;
    int bad = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); cmp_vld = 1'b1; cmp_word = pat(10, i);
    end
    @(negedge clk);
    cmp_vld = 1'b0; cmp_end = 1'b1; cmp_ok = 1'b1; cmp_line = LW'(10);
    for (int c = 0; c < 80; c++) begin
      @(negedge clk);
      cmp_end = 1'b0; cmp_vld = 1'b0; cmp_ok = 1'b0;
      if (wb_vld) begin
        cnt++;
        if (wb_line != LW'(10)) bad++;
      end
      if (c >= 2 && c < 5) begin cmp_vld = 1'b1; cmp_word = pat(11, c); end
      if (c == 5) begin cmp_end = 1'b1; cmp_ok = 1'b1; cmp_line = LW'(11); end
    end
    chk(cnt == 64 && bad == 0, "R10 only the busy line written back", cnt, 64);
    query(10, 1'b1, "R10 busy line committed");
    query(11, 1'b0, "R10 line ended during write-back failed");
    // words lost while busy poison the next line
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); cmp_vld = 1'b1; cmp_word = pat(13, i);
    end
    @(negedge clk); cmp_vld = 1'b0; cmp_end = 1'b1; cmp_ok = 1'b1; cmp_line = LW'(13);
    @(negedge clk); cmp_end = 1'b0; cmp_ok = 1'b0;
    bad = 0;
    for (int c = 0; c < 4; c++) begin
      if (!wb_vld || wb_line != LW'(13)) bad++;
      if (c == 1) cmp_vld = 1'b1;
      if (c == 2) cmp_vld = 1'b0;
      @(negedge clk);
    end
    chk(bad == 2, "R10 short line written back", bad, 2);
    run_line(14, 3, 1'b1, 1'b0, 1'b0, 0, "R10 line with lost word fails");
    query(14, 1'b0, "R10 lost-word line uncompressed");
  endtask

  initial begin
    #50_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_success;
    t_snoop_static;
    t_fail;
    t_collide;
    t_busy;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule